// File: doc/BRIEF.md
# Two-level interrupt status aggregator

This block gathers single-cycle event pulses into a set of secondary status registers and summarises them into one primary status word. The per-queue transmit events (success, descriptor done, error, end of list, underrun), the rate-control overrun and underrun events, the queue trigger events, the beacon-related events and the host bus error events each land in their own secondary field. Two receive events land directly in the primary word.

Most primary bits are not stored. Each one is a live OR of a secondary field, so software can read one word to find which group needs service. It then reads the matching secondary register to find the queue. A primary mask and a global enable decide whether the interrupt line is driven.

All status registers clear when a one is written to them. Writing a one to a summary bit in the primary word clears the whole secondary field behind it. A pending register reads 1 exactly while the line is asserted. The parameter NQ (default 4) sets the number of queues.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status register, both mask registers and the enable register read 0, and `irq` is low.
- R2: Register addresses: 0 primary status, 1 primary mask, 2 secondary 0, 3 secondary 1, 4 secondary 2, 5 secondary 3, 6 secondary 4, 7 secondary mask 2, 8 enable, 9 pending. Field layouts:
  - Secondary 0 holds success in bits [NQ-1:0] and descriptor-done in [2NQ-1:NQ].
  - Secondary 1 holds error in the low NQ bits and end-of-list in the next NQ bits.
  - Secondary 3 holds overrun in the low NQ bits and underrun in the next NQ bits.
  - Secondary 4 holds trigger in [NQ-1:0].
  - Secondary 2 holds underrun in [NQ-1:0], then from bit NQ upward: beacon TIM, DTIM, DTIM sync, beacon timeout, content-after-beacon timeout, content-after-beacon end, master abort, system error, parity error.
  
  An event pulse in a cycle sets its bit at the next clock edge.
- R3: Primary bits are live ORs of secondary fields:
  - 0: secondary 0 success field.
  - 1: secondary 0 descriptor-done field.
  - 2: secondary 1 error field.
  - 3: secondary 1 end-of-list field.
  - 4: transmit underrun.
  - 5: host error.
  - 6: beacon group.
  - 7: secondary 3 overrun field.
  - 8: secondary 3 underrun field.
  - 9: secondary 4 trigger field.
  
  Bits 10 (receive ok) and 11 (receive error) are stored event bits.
- R4: Secondary mask 2 uses the same bit positions as secondary 2 for underrun and the five beacon bits TIM through content-after-beacon timeout. A masked bit still records its event but does not feed primary bit 4 or 6. Content-after-beacon end always feeds bit 6, and the three host error bits always feed bit 5.
- R5: Writing a secondary status register clears the bits written as 1 and leaves bits written as 0 unchanged.
- R6: Writing 1 to a primary summary bit clears every bit of the secondary field behind it: bit 6 clears all six beacon bits, bit 5 the three host error bits. Writing 1 to bit 10 or 11 clears it.
- R7: An event arriving in the same cycle as a clearing write to its bit leaves the bit set.
- R8: `irq` is high exactly when the enable is on and some primary status bit is set together with its primary mask bit.
- R9: Writing 1 to the enable register turns it on, writing 0 turns it off, and any other value leaves it unchanged. It reads back as 1 or 0.
- R10: The pending register reads exactly 1 while `irq` is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_txok | input | NQ | Per-queue transmit success pulses |
| ev_txdesc | input | NQ | Per-queue descriptor done pulses |
| ev_txerr | input | NQ | Per-queue transmit error pulses |
| ev_txeol | input | NQ | Per-queue end-of-list pulses |
| ev_txurn | input | NQ | Per-queue transmit underrun pulses |
| ev_cbrorn | input | NQ | Per-queue rate-control overrun pulses |
| ev_cbrurn | input | NQ | Per-queue rate-control underrun pulses |
| ev_trig | input | NQ | Per-queue trigger pulses |
| ev_misc | input | 9 | Beacon and host error pulses, in the secondary 2 order |
| ev_rx | input | 2 | Receive ok (bit 0) and receive error (bit 1) pulses |
| reg_addr | input | AW | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the addressed register |
| irq | output | 1 | Interrupt line |

## Verification
The bench aims at the places where the two levels interact:
- It clears through the primary word and checks that the whole secondary field empties. A design that only dropped the summary would leave it reasserting.
- It raises masked beacon and underrun events and checks that they are recorded but not summarised. Host error and content-after-beacon end are checked to bypass the mask.
- It collides an event with a clearing write and expects the bit to survive; a design with clear priority would lose the event.
- It writes zeros, and a non-code value to the enable register, and expects nothing to move.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NQ = 4,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] ev_txok,
  input  logic [NQ-1:0] ev_txdesc,
  input  logic [NQ-1:0] ev_txerr,
  input  logic [NQ-1:0] ev_txeol,
  input  logic [NQ-1:0] ev_txurn,
  input  logic [NQ-1:0] ev_cbrorn,
  input  logic [NQ-1:0] ev_cbrurn,
  input  logic [NQ-1:0] ev_trig,
  input  logic [8:0]    ev_misc,
  input  logic [1:0]    ev_rx,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int WP = 2 * NQ;
  localparam int W2 = NQ + 9;
  localparam int WM = NQ + 5;
  localparam int PB = 12;

  localparam logic [AW-1:0] A_PST = AW'(0), A_PMK = AW'(1), A_S0 = AW'(2), A_S1 = AW'(3),
                            A_S2 = AW'(4), A_S3 = AW'(5), A_S4 = AW'(6), A_SM2 = AW'(7),
                            A_GEN = AW'(8), A_PND = AW'(9);

  logic [WP-1:0] s0, s1, s3;
  logic [W2-1:0] s2;
  logic [NQ-1:0] s4;
  logic [1:0]    pdir;
  logic [PB-1:0] pmask, pstat;
  logic [WM-1:0] smask2;
  logic          gen;

  wire wp  = reg_wr && reg_addr == A_PST;
  wire [PB-1:0] pw = wp ? reg_wdata[PB-1:0] : '0;

  wire [NQ-1:0] s2_urn  = s2[NQ-1:0];
  wire [8:0]    s2_misc = s2[W2-1:NQ];
  wire          sum_urn = |(s2_urn & smask2[NQ-1:0]);
  wire          sum_hiu = |s2_misc[8:6];
  wire          sum_bcn = s2_misc[5] | |(s2_misc[4:0] & smask2[WM-1:NQ]);

  assign pstat = {pdir, |s4, |s3[WP-1:NQ], |s3[NQ-1:0], sum_bcn, sum_hiu, sum_urn,
                  |s1[WP-1:NQ], |s1[NQ-1:0], |s0[WP-1:NQ], |s0[NQ-1:0]};

  wire [WP-1:0] clr0 = ((reg_wr && reg_addr == A_S0) ? reg_wdata[WP-1:0] : '0)
                     | {{NQ{pw[1]}}, {NQ{pw[0]}}};
  wire [WP-1:0] clr1 = ((reg_wr && reg_addr == A_S1) ? reg_wdata[WP-1:0] : '0)
                     | {{NQ{pw[3]}}, {NQ{pw[2]}}};
  wire [WP-1:0] clr3 = ((reg_wr && reg_addr == A_S3) ? reg_wdata[WP-1:0] : '0)
                     | {{NQ{pw[8]}}, {NQ{pw[7]}}};
  wire [NQ-1:0] clr4 = ((reg_wr && reg_addr == A_S4) ? reg_wdata[NQ-1:0] : '0)
                     | {NQ{pw[9]}};
  wire [W2-1:0] clr2 = ((reg_wr && reg_addr == A_S2) ? reg_wdata[W2-1:0] : '0)
                     | {{3{pw[5]}}, {6{pw[6]}}, {NQ{pw[4]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= '0; s1 <= '0; s2 <= '0; s3 <= '0; s4 <= '0; pdir <= '0;
      pmask <= '0; smask2 <= '0; gen <= 1'b0;
    end else begin
      s0   <= (s0 & ~clr0) | {ev_txdesc, ev_txok};
      s1   <= (s1 & ~clr1) | {ev_txeol, ev_txerr};
      s2   <= (s2 & ~clr2) | {ev_misc, ev_txurn};
      s3   <= (s3 & ~clr3) | {ev_cbrurn, ev_cbrorn};
      s4   <= (s4 & ~clr4) | ev_trig;
      pdir <= (pdir & ~pw[11:10]) | ev_rx;
      if (reg_wr && reg_addr == A_PMK) pmask  <= reg_wdata[PB-1:0];
      if (reg_wr && reg_addr == A_SM2) smask2 <= reg_wdata[WM-1:0];
      if (reg_wr && reg_addr == A_GEN) begin
        if (reg_wdata == DW'(1))      gen <= 1'b1;
        else if (reg_wdata == '0)     gen <= 1'b0;
      end
    end
  end

  assign irq = gen && |(pstat & pmask);

  always_comb begin
    case (reg_addr)
      A_PST:   reg_rdata = DW'(pstat);
      A_PMK:   reg_rdata = DW'(pmask);
      A_S0:    reg_rdata = DW'(s0);
      A_S1:    reg_rdata = DW'(s1);
      A_S2:    reg_rdata = DW'(s2);
      A_S3:    reg_rdata = DW'(s3);
      A_S4:    reg_rdata = DW'(s4);
      A_SM2:   reg_rdata = DW'(smask2);
      A_GEN:   reg_rdata = DW'(gen);
      A_PND:   reg_rdata = DW'(irq);
      default: reg_rdata = '0;
    endcase
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_txok) |=> ((s0[NQ-1:0] & $past(ev_txok)) == $past(ev_txok)));
  a_r5_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_S1 && reg_wdata == '0) |=> ((s1 & $past(s1)) == $past(s1)));
  a_r6_summary_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && reg_wdata[0] && ev_txok == '0) |=> !pstat[0]);
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_S0 && reg_wdata[0] && ev_txok[0]) |=> s0[0]);
  a_r9_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_GEN && reg_wdata == '0) |=> !irq);
  a_r10_pending_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_PND) |-> (reg_rdata == DW'(irq)));
endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  localparam int NQ = 4, DW = 32, AW = 4;
  logic clk = 0, rst_n = 0;
  logic [NQ-1:0] ev_txok = 0, ev_txdesc = 0, ev_txerr = 0, ev_txeol = 0, ev_txurn = 0,
                 ev_cbrorn = 0, ev_cbrurn = 0, ev_trig = 0;
  logic [8:0] ev_misc = 0;
  logic [1:0] ev_rx = 0;
  logic [AW-1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic irq;

  always #2.5 clk = ~clk;

  irq_aggregator #(.NQ(NQ), .DW(DW), .AW(AW)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .ev_txok(ev_txok), .ev_txdesc(ev_txdesc), .ev_txerr(ev_txerr),
    .ev_txeol(ev_txeol), .ev_txurn(ev_txurn), .ev_cbrorn(ev_cbrorn), .ev_cbrurn(ev_cbrurn),
    .ev_trig(ev_trig), .ev_misc(ev_misc), .ev_rx(ev_rx), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  typedef struct { int a; logic [DW-1:0] exp; string tag; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  initial forever begin
    @(posedge clk); #1;
    while (q.size() > 0) begin
      item_t it;
      logic [DW-1:0] act;
      it = q.pop_front();
      act = (it.a < 0) ? DW'(irq) : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, act, it.exp);
      end
    end
  end

  task automatic chk(input int a, input logic [DW-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = (a < 0) ? AW'(0) : AW'(a);
    it.a = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic clear_ev;
    ev_txok = 0; ev_txdesc = 0; ev_txerr = 0; ev_txeol = 0; ev_txurn = 0;
    ev_cbrorn = 0; ev_cbrurn = 0; ev_trig = 0; ev_misc = 0; ev_rx = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(0, 0, "R1 primary");
    chk(2, 0, "R1 sec0");
    chk(8, 0, "R1 enable");
    chk(9, 0, "R1 pending");
    chk(-1, 0, "R1 irq");

    @(negedge clk); ev_txok = 4'b0100; @(negedge clk); clear_ev();
    chk(2, 32'h04, "R2 sec0 ok");
    chk(0, 32'h001, "R3 primary ok");
    @(negedge clk); ev_txdesc = 4'b0001; @(negedge clk); clear_ev();
    chk(2, 32'h14, "R2 sec0 desc");
    chk(0, 32'h003, "R3 primary desc");
    wr(2, 32'h04);
    chk(2, 32'h10, "R5 w1c");
    chk(0, 32'h002, "R3 summary follows");
    wr(2, 32'h0);
    chk(2, 32'h10, "R5 zero write");

    wr(1, 32'h002);
    chk(-1, 0, "R8 no enable");
    wr(8, 32'h1);
    chk(-1, 1, "R8 enabled");
    chk(9, 1, "R10 pending one");
    wr(8, 32'h5);
    chk(8, 1, "R9 other code ignored");
    wr(8, 32'h0);
    chk(-1, 0, "R9 disabled");
    chk(9, 0, "R10 pending zero");
    wr(8, 32'h1);
    wr(1, 32'h001);
    chk(-1, 0, "R8 masked");
    wr(1, 32'h002);
    wr(0, 32'h002);
    chk(2, 0, "R6 summary clears field");
    chk(0, 0, "R6 primary empty");
    chk(-1, 0, "R8 irq drops");

    @(negedge clk); ev_txurn = 4'b0010; @(negedge clk); clear_ev();
    chk(4, 32'h002, "R2 sec2 urn");
    chk(0, 32'h000, "R4 masked urn");
    wr(7, 32'h002);
    chk(0, 32'h010, "R4 unmasked urn");
    @(negedge clk); ev_misc = 9'h020; @(negedge clk); clear_ev();
    chk(0, 32'h050, "R4 cab end bypasses mask");
    @(negedge clk); ev_misc = 9'h040; @(negedge clk); clear_ev();
    chk(0, 32'h070, "R4 host error");
    @(negedge clk); ev_misc = 9'h001; @(negedge clk); clear_ev();
    chk(4, 32'h612, "R2 sec2 misc");
    chk(0, 32'h070, "R4 masked tim");
    wr(0, 32'h040);
    chk(4, 32'h402, "R6 beacon group cleared");
    wr(0, 32'h020);
    chk(4, 32'h002, "R6 host group cleared");
    chk(0, 32'h010, "R6 primary after");

    @(negedge clk);
    ev_txurn = 4'b0010; reg_addr = 4; reg_wdata = 32'h002; reg_wr = 1;
    @(negedge clk); clear_ev(); reg_wr = 0; reg_wdata = 0;
    chk(4, 32'h002, "R7 event wins secondary");
    wr(4, 32'h002);
    chk(4, 0, "R5 sec2 cleared");

    @(negedge clk); ev_rx = 2'b01; @(negedge clk); clear_ev();
    chk(0, 32'h400, "R3 rx direct");
    wr(0, 32'h400);
    chk(0, 0, "R6 rx cleared");
    @(negedge clk);
    ev_rx = 2'b10; reg_addr = 0; reg_wdata = 32'h800; reg_wr = 1;
    @(negedge clk); clear_ev(); reg_wr = 0; reg_wdata = 0;
    chk(0, 32'h800, "R7 event wins primary");
    wr(0, 32'h800);

    @(negedge clk); ev_txeol = 4'b1000; ev_cbrorn = 4'b0001; ev_trig = 4'b0100;
    @(negedge clk); clear_ev();
    chk(3, 32'h80, "R2 sec1 eol");
    chk(5, 32'h01, "R2 sec3 orn");
    chk(6, 32'h04, "R2 sec4 trig");
    chk(0, 32'h288, "R3 mixed summary");
    wr(0, 32'h288);
    chk(0, 0, "R6 multi clear");
    chk(3, 0, "R6 sec1 cleared");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule